// File: doc/BRIEF.md
# Word-Pair OR Memory Loader

This block fills a word-addressed memory from a stream of 32-bit words arriving on a simple valid/ready channel, without help from any processor. The memory is 36 bits wide: 32 data bits and one parity bit for each of the four data bytes. Words are taken two at a time. The first word of each pair is written straight into the current location together with the parity the block generates for it. The second word is merged into the same location by a read-modify-write: the stored word is read back, OR'ed with the second word and that word's generated parity, and written again. Because the parity bits are OR'ed like data, a pair can leave a location holding deliberately wrong parity. This makes the block suitable for loading test images that must contain bad-parity words.

Loading begins at byte address zero whenever `start` is pulsed. The address then moves one fullword (four bytes) each time a pair completes. No record length is checked. If the stream stops after an odd number of words, the block waits for the missing partner word for as long as it takes. `busy` stays high during that wait, which tells the system the load has hung. The memory is assumed to return read data one cycle after a read strobe and to write in the cycle its write strobe is high.

Top module: `pair_or_loader`

## Requirements
- R1: After reset `in_ready` is 1, `busy` is 0, `mem_rd` and `mem_wr` are 0, and `mem_addr` is 0.
- R2: A word taken as the first of a pair produces exactly one write, in the cycle it is accepted, at the current address. The write data is {parity[3:0], data[31:0]}. Parity bit i is the odd-parity bit of byte i (data bits 8i+7..8i), so it is 1 when that byte holds an even number of ones.
- R3: A word taken as the second of a pair raises `mem_rd` at the current address in the cycle it is accepted. In the following cycle `mem_wr` writes back to that same address.
- R4: A completed pair leaves the location holding the bitwise OR of both words in bits 31..0 and the bitwise OR of both generated parity nibbles in bits 35..32. The result may carry parity that does not match its data.
- R5: `in_ready` is 0 in the cycle after each read strobe (the write-back cycle). Each pair costs exactly one such stall cycle.
- R6: The address advances by 4 after each write-back, so pair k is stored at byte address 4k. It wraps modulo 2^ADDR_W.
- R7: `mem_rd` and `mem_wr` are never high in the same cycle. Each completed pair uses exactly two writes and one read.
- R8: After an odd number of words, `busy` stays 1 and `in_ready` stays 1, and no read or write occurs until another word arrives or `start` is pulsed.
- R9: `start` sets the address to 0 and drops any half-finished pair at the next edge. This includes a write-back that was due in the same cycle as `start`, which is suppressed. After the edge `busy` is 0.
- R10: While `start` is high, `in_ready` is 0 and no word offered on the channel is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart: address to 0, pair state cleared |
| in_valid | input | 1 | Channel word valid |
| in_data | input | DATA_W | Channel word |
| in_ready | output | 1 | Loader can take a word this cycle |
| mem_addr | output | ADDR_W | Byte address of the memory access |
| mem_wdata | output | DATA_W+DATA_W/8 | Write data {parity, data} |
| mem_rdata | input | DATA_W+DATA_W/8 | Read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | A pair has been opened and is not yet complete |

## Verification
The hardest situation to reach from the ports is a `start` that lands exactly on the single write-back cycle of a pair. At that moment the read has already happened, but the merged write must not occur. The bench's word-sending task returns in precisely that cycle after handing over a second word, and the bench raises `start` at once. It then checks that the location still holds only the first word with its own parity. The bench also leaves the stream hanging after an odd word count for many idle cycles, and only later supplies the partner word, so that the stuck state and its recovery are both seen at the memory interface.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  // Pair phase of the loader
  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,  // waiting for the first word of a pair
    ST_SECOND = 2'd1,  // first word stored, waiting for its partner
    ST_MERGE  = 2'd2   // read data back, OR-merged write-back this cycle
  } ldr_state_e;

  // Odd parity bit for one byte: set when the byte has an even count of ones
  function automatic logic odd_par8(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/ldr_parity.sv
module ldr_parity #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  par
);
  import ldr_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = odd_par8(data[g*8 +: 8]);
  end

endmodule

// File: rtl/ldr_seq.sv
module ldr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  output logic ev_first_wr,
  output logic ev_rd,
  output logic ev_merge_wr,
  output logic busy
);
  import ldr_pkg::*;

  ldr_state_e state_q, state_d;
  logic       accept;

  assign in_ready    = !start && (state_q != ST_MERGE);
  assign accept      = in_valid && in_ready;
  assign ev_first_wr = accept && (state_q == ST_FIRST);
  assign ev_rd       = accept && (state_q == ST_SECOND);
  assign ev_merge_wr = !start && (state_q == ST_MERGE);
  assign busy        = (state_q != ST_FIRST);

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_FIRST;
    end else begin
      case (state_q)
        ST_FIRST:  if (accept) state_d = ST_SECOND;
        ST_SECOND: if (accept) state_d = ST_MERGE;
        ST_MERGE:  state_d = ST_FIRST;
        default:   state_d = ST_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FIRST;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ldr_addr.sv
module ldr_addr #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + STEP_V;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clear) addr <= '0;
    else if (step)  addr <= next_addr(addr);
  end

endmodule

// File: rtl/pair_or_loader.sv
module pair_or_loader #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_data,
  output logic                         in_ready,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W+DATA_W/8-1:0]   mem_wdata,
  input  logic [DATA_W+DATA_W/8-1:0]   mem_rdata,
  output logic                         mem_rd,
  output logic                         mem_wr,
  output logic                         busy
);

  localparam int LANES  = DATA_W / 8;
  localparam int WORD_W = DATA_W + LANES;
  localparam int STEP   = DATA_W / 8;   // one fullword in bytes

  // Named internal events, brought out for the checker
  logic ev_first_wr;
  logic ev_rd;
  logic ev_merge_wr;

  logic [LANES-1:0]  par_in;
  logic [WORD_W-1:0] word_in;
  logic [WORD_W-1:0] held_q;

  function automatic logic [WORD_W-1:0] or_merge(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a | b;
  endfunction

  ldr_parity #(.DATA_W(DATA_W)) u_par (
    .data (in_data),
    .par  (par_in)
  );

  ldr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .ev_first_wr (ev_first_wr),
    .ev_rd       (ev_rd),
    .ev_merge_wr (ev_merge_wr),
    .busy        (busy)
  );

  ldr_addr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .step  (ev_merge_wr),
    .addr  (mem_addr)
  );

  assign word_in = {par_in, in_data};

  // Second word (with its own parity) is held across the read cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (ev_rd) held_q <= word_in;
  end

  assign mem_rd    = ev_rd;
  assign mem_wr    = ev_first_wr || ev_merge_wr;
  assign mem_wdata = ev_merge_wr ? or_merge(held_q, mem_rdata) : word_in;

endmodule

// File: rtl/pair_or_loader_chk.sv
module pair_or_loader_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int WORD_W = DATA_W + LANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              busy,
  input logic              ev_first_wr,
  input logic              ev_merge_wr
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(DATA_W / 8);

  // Per-lane check that a first write carries odd parity (count of ones odd)
  logic [LANES-1:0] lane_odd;
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assign lane_odd[g] = ($countones({mem_wdata[DATA_W+g], mem_wdata[g*8 +: 8]}) % 2) == 1;
  end

  assert_no_rdwr_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_first_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first_wr |-> (&lane_odd));

  assert_merge_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr || start));

  assert_rd_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(mem_addr));

  assert_merge_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_merge_wr |-> ((mem_wdata & mem_rdata) == mem_rdata));

  assert_merge_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !in_ready);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_merge_wr && !start) |=> (mem_addr == ADDR_W'($past(mem_addr) + STEP_V)));

  assert_hang_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_ready && !in_valid) |-> !(mem_rd || mem_wr));

  assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_addr == '0 && !busy));

  assert_start_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!in_ready && !mem_wr && !mem_rd));

endmodule

bind pair_or_loader pair_or_loader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_rdata   (mem_rdata),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .busy        (busy),
  .ev_first_wr (ev_first_wr),
  .ev_merge_wr (ev_merge_wr)
);

// File: tb/pair_or_loader_bench.sv
`timescale 1ns/1ps
module pair_or_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic [15:0] mem_addr;
  logic [35:0] mem_wdata;
  logic [35:0] mem_rdata;
  logic        mem_rd;
  logic        mem_wr;
  logic        busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pair_or_loader u_pair_or_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .busy(busy)
  );

  // Bench memory: 64 words, read data one cycle after the strobe
  logic [35:0] bmem [0:63];
  int wr_cnt = 0, rd_cnt = 0, stall_cnt = 0;

  always @(posedge clk) begin
    if (mem_wr) begin bmem[mem_addr[7:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_rd) begin mem_rdata <= bmem[mem_addr[7:2]]; rd_cnt <= rd_cnt + 1; end
  end

  always @(negedge clk)
    if (rst_n === 1'b1 && !in_ready && !start) stall_cnt <= stall_cnt + 1;

  // Expected parity: bit set when the byte carries an even number of ones
  function automatic logic [3:0] gen_par(input logic [31:0] w);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ($countones(w[i*8 +: 8]) % 2) == 0;
    return p;
  endfunction

  function automatic logic [35:0] exp_pair(input logic [31:0] a, input logic [31:0] b);
    return {gen_par(a) | gen_par(b), a | b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [31:0] w);
    bit ok;
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      ok = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) bmem[i] <= '0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  logic [31:0] wa [0:63];
  logic [31:0] wb [0:63];

  initial begin
    int w0, r0, s0;
    logic [31:0] odd_w, part_w, x_w, y_w, c1, c2;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0; mem_rdata = '0;
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(!mem_wr && !mem_rd, "R1 strobes", {mem_wr, mem_rd}, 0);
    chk(mem_addr == 16'h0, "R1 addr", mem_addr, 0);

    // Stream of 32 pairs: directed corners then random
    wa[0] = 32'h0000_0001; wb[0] = 32'h0000_0002;  // OR leaves bad parity
    wa[1] = 32'hFFFF_FFFF; wb[1] = 32'h0000_0000;
    wa[2] = 32'h0000_0000; wb[2] = 32'h0000_0000;
    wa[3] = 32'hA5A5_A5A5; wb[3] = 32'h5A5A_5A5A;
    for (int k = 4; k < 32; k++) begin wa[k] = $urandom; wb[k] = $urandom; end
    w0 = wr_cnt; r0 = rd_cnt; s0 = stall_cnt;
    for (int k = 0; k < 32; k++) begin
      gap(); send(wa[k]);
      gap(); send(wb[k]);
    end
    repeat (2) @(negedge clk);
    // R4: data and parity ORed; directed pair 0 stores parity not matching its data
    chk(bmem[0] == 36'hE_0000_0003, "R4 bad parity pair", bmem[0], 36'hE_0000_0003);
    chk(bmem[0][35:32] != gen_par(bmem[0][31:0]), "R4 parity mismatch kept", bmem[0][35:32], ~gen_par(32'h3));
    for (int k = 0; k < 32; k++)
      chk(bmem[k] == exp_pair(wa[k], wb[k]), "R4 R6 stored pair", bmem[k], exp_pair(wa[k], wb[k]));
    chk(bmem[32] == '0, "R6 nothing past last pair", bmem[32], 0);
    chk(mem_addr == 16'd128, "R6 address after 32 pairs", mem_addr, 128);
    chk(wr_cnt - w0 == 64, "R7 writes per pair", wr_cnt - w0, 64);
    chk(rd_cnt - r0 == 32, "R7 reads per pair", rd_cnt - r0, 32);
    chk(stall_cnt - s0 == 32, "R5 one stall per pair", stall_cnt - s0, 32);

    // R10: start with a word offered: not taken
    w0 = wr_cnt;
    start = 1'b1; in_valid = 1'b1; in_data = 32'h1234_5678;
    #1;
    chk(in_ready == 1'b0, "R10 ready low in start", in_ready, 0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk(wr_cnt == w0, "R10 no write during start", wr_cnt - w0, 0);
    chk(mem_addr == 16'h0, "R9 start clears addr", mem_addr, 0);
    clear_mem();

    // R8: odd word count hangs
    for (int k = 0; k < 3; k++) begin wa[k] = $urandom; wb[k] = $urandom; end
    w0 = wr_cnt; r0 = rd_cnt;
    for (int k = 0; k < 3; k++) begin send(wa[k]); gap(); send(wb[k]); end
    odd_w = $urandom;
    send(odd_w);
    repeat (30) @(negedge clk);
    chk(busy == 1'b1, "R8 busy while hung", busy, 1);
    chk(in_ready == 1'b1, "R8 ready while hung", in_ready, 1);
    chk(wr_cnt - w0 == 7, "R8 writes while hung", wr_cnt - w0, 7);
    chk(rd_cnt - r0 == 3, "R8 reads while hung", rd_cnt - r0, 3);
    chk(bmem[3] == {gen_par(odd_w), odd_w}, "R2 lone first word", bmem[3], {gen_par(odd_w), odd_w});
    chk(bmem[4] == '0, "R8 next slot untouched", bmem[4], 0);

    // R3: partner word finally arrives
    part_w = $urandom;
    send(part_w);
    chk(in_ready == 1'b0, "R5 stall after late partner", in_ready, 0);
    repeat (2) @(negedge clk);
    chk(bmem[3] == exp_pair(odd_w, part_w), "R3 late merge", bmem[3], exp_pair(odd_w, part_w));
    chk(busy == 1'b0, "R3 pair closed", busy, 0);

    // R9: start in the write-back cycle drops the merge
    x_w = 32'h0F0F_0001; y_w = 32'hF0F0_8000;
    w0 = wr_cnt;
    send(x_w);
    send(y_w);
    pulse_start();
    @(negedge clk);
    chk(bmem[4] == {gen_par(x_w), x_w}, "R9 merge suppressed", bmem[4], {gen_par(x_w), x_w});
    chk(wr_cnt - w0 == 1, "R9 only first write", wr_cnt - w0, 1);
    chk(busy == 1'b0, "R9 busy cleared", busy, 0);
    chk(mem_addr == 16'h0, "R9 addr cleared", mem_addr, 0);
    c1 = $urandom; c2 = $urandom;
    send(c1); send(c2);
    repeat (2) @(negedge clk);
    chk(bmem[0] == exp_pair(c1, c2), "R9 reload at zero", bmem[0], exp_pair(c1, c2));
    chk(mem_addr == 16'd4, "R6 step after reload", mem_addr, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule